// File: doc/BRIEF.md
# Three-Line Vertical Flicker Filter

This block smooths a progressive stream of 8-bit luma and chroma samples in the vertical direction, so that a picture shown on an interlaced display does not shimmer. Every output sample is a weighted blend of three vertically adjacent samples at the same column: one from the line above, one from the centre line and one from the line below. The block keeps the two most recent lines in internal line memories. A centre line is therefore emitted while the line after it streams in, and the output lags the input by one line.

The kernel is chosen at run time from four choices: straight pass-through, 1:3:1, 1:2:1 and 1:1:1. Each weighted sum is divided by the sum of its weights, rounded to nearest and limited to the 8-bit range. An underscan flag overrides the select and forces 1:2:1. At the top and bottom of a frame the missing neighbour line is replaced by the centre line.

A source drives `pixValid` for each sample. It raises `lineStart` together with the first sample of every line and `frameStart` together with the first sample of every frame. The last line of a frame is released when the first line of the next frame arrives.

Top module: `vert_flicker_filter`

## Requirements
- R1: With the select at 00 (pass-through), each output sample equals the centre-line sample at its column.
- R2: With select 01 (1:3:1), the output is (above + 3*centre + below + 2) / 5, integer division, limited to 255.
- R3: With select 10 (1:2:1), the output is (above + 2*centre + below + 2) / 4, limited to 255.
- R4: With select 11 (1:1:1), the output is (above + centre + below + 1) / 3, limited to 255.
- R5: While `underscan` is high, the 1:2:1 kernel of R3 is used whatever the select is.
- R6: For the first line of a frame (the line whose first sample had `frameStart`), the centre sample is used in place of the line above.
- R7: For a line that is followed by a line carrying `frameStart`, the centre sample is used in place of the line below.
- R8: The output for line L at column k becomes valid exactly two clock cycles after the sample at column k of line L+1 is accepted. It uses the select and underscan values present with that later sample. No output is produced while the first line after reset arrives.
- R9: Cycles with `pixValid` low change nothing, and any `lineStart` or `frameStart` seen in them is ignored.
- R10: During and right after reset, `outValid` is low.
- R11: The column index restarts at 0 on each accepted `lineStart` and advances once per accepted sample. Lines of different lengths combine column by column with whatever each line memory last held at that column. The memory depth `DEPTH` is a parameter of at least 800, and the index wraps after `DEPTH-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Sample strobe |
| lineStart | input | 1 | High with the first sample of a line |
| frameStart | input | 1 | High with the first sample of a frame (always with lineStart) |
| modeSel | input | 2 | Kernel select: 00 pass, 01 1:3:1, 10 1:2:1, 11 1:1:1 |
| underscan | input | 1 | Forces the 1:2:1 kernel |
| lumaIn | input | W | Luma sample |
| chromaIn | input | W | Chroma sample |
| outValid | output | 1 | Output sample strobe |
| lumaOut | output | W | Filtered luma |
| chromaOut | output | W | Filtered chroma |

## Verification
The first directed frames use ramps and 0/255/0 stripes under each kernel. These show whether the weights, the rounding offset and the divisor are right, and which line memory feeds which tap. A one-line frame and a frame boundary test the top and bottom substitution: a frame change halfway through a stream shows whether above and below are swapped or stale. Underscan is applied together with the pass-through select to separate the override from the register setting. Random frames then mix line counts, line lengths, select changes within a frame, and idle cycles that carry stray markers. A wrong strobe alignment or a marker honoured while idle shows up as a valid or data mismatch.

// File: rtl/flick_pkg.sv
package flick_pkg;

  typedef enum logic [1:0] {
    K_PASS = 2'b00,
    K_131  = 2'b01,
    K_121  = 2'b10,
    K_111  = 2'b11
  } kernel_e;

  // strobes from control to datapath for the current input sample
  typedef struct packed {
    logic wr;        // sample accepted
    logic emit;      // centre line holds real data
    logic useAbove;  // above line belongs to the same frame
    logic useBelow;  // incoming line belongs to the same frame
  } ctl_s;

endpackage

// File: rtl/flick_ctrl.sv
module flick_ctrl
  import flick_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pixValid,
  input  logic          lineStart,
  input  logic          frameStart,
  output ctl_s          ctl,
  output logic [AW-1:0] addr
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] colCnt;
  logic seenLine, prevFirst, emitR, aboveR, belowR;
  logic startPix;

  assign startPix = pixValid & lineStart;
  assign addr     = startPix ? '0 : colCnt;

  always_comb begin
    ctl.wr       = pixValid;
    ctl.emit     = startPix ? seenLine    : emitR;
    ctl.useAbove = startPix ? !prevFirst  : aboveR;
    ctl.useBelow = startPix ? !frameStart : belowR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      colCnt    <= '0;
      seenLine  <= 1'b0;
      prevFirst <= 1'b1;
      emitR     <= 1'b0;
      aboveR    <= 1'b0;
      belowR    <= 1'b0;
    end else if (pixValid) begin
      colCnt <= (addr == LAST) ? '0 : addr + 1'b1;
      if (lineStart) begin
        emitR     <= seenLine;
        aboveR    <= !prevFirst;
        belowR    <= !frameStart;
        prevFirst <= frameStart | !seenLine;
        seenLine  <= 1'b1;
      end
    end
  end

  // R9: idle cycles leave the column index alone
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> (lineStart && pixValid) || addr == $past(addr));

  // R11: the column index wraps after the last memory word
  a_r11_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && addr == LAST) |=> (addr == '0));

endmodule

// File: rtl/flick_datapath.sv
module flick_datapath
  import flick_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int W = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = 2 * W,
  localparam int SW = W + 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctl_s          ctl,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    modeIn,
  input  logic          usIn,
  input  logic [PW-1:0] pixIn,
  output logic          outValid,
  output logic [PW-1:0] pixOut
);

  logic [PW-1:0] memC [DEPTH];
  logic [PW-1:0] memA [DEPTH];
  logic [PW-1:0] centre, above, below;
  logic [PW-1:0] aR, cR, bR;
  kernel_e kEff, kR;
  logic vR;
  logic [PW-1:0] filt;

  function automatic logic [W-1:0] applyKernel(input logic [W-1:0] a, c, b,
                                                input kernel_e k);
    logic [SW-1:0] s, q;
    s = '0;
    q = '0;
    case (k)
      K_PASS: q = SW'(c);
      K_131: begin
        s = SW'(a) + SW'(c) * SW'(3) + SW'(b);
        q = (s + SW'(2)) / SW'(5);
      end
      K_121: begin
        s = SW'(a) + (SW'(c) << 1) + SW'(b);
        q = (s + SW'(2)) >> 2;
      end
      default: begin
        s = SW'(a) + SW'(c) + SW'(b);
        q = (s + SW'(1)) / SW'(3);
      end
    endcase
    return (q > SW'({W{1'b1}})) ? {W{1'b1}} : q[W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (ctl.wr) begin
      memA[addr] <= memC[addr];
      memC[addr] <= pixIn;
    end
  end

  assign centre = memC[addr];
  assign above  = ctl.useAbove ? memA[addr] : centre;
  assign below  = ctl.useBelow ? pixIn : centre;
  assign kEff   = usIn ? K_121 : kernel_e'(modeIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vR <= 1'b0;
      aR <= '0;
      cR <= '0;
      bR <= '0;
      kR <= K_PASS;
    end else begin
      vR <= ctl.wr & ctl.emit;
      if (ctl.wr) begin
        aR <= above;
        cR <= centre;
        bR <= below;
        kR <= kEff;
      end
    end
  end

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    assign filt[ch*W +: W] = applyKernel(aR[ch*W +: W], cR[ch*W +: W],
                                         bR[ch*W +: W], kR);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      pixOut   <= '0;
    end else begin
      outValid <= vR;
      if (vR) pixOut <= filt;
    end
  end

  // R8: a valid output is always two cycles behind an accepted sample
  a_r8_latency: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(ctl.wr, 2));

  // R1: pass-through returns the centre tap untouched
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(kR) == K_PASS) |-> pixOut == $past(cR));

  // R5: underscan at the input selects the 1:2:1 kernel in the next stage
  a_r5_underscan: assert property (@(posedge clk) disable iff (!rstN)
    (vR && $past(usIn)) |-> kR == K_121);

endmodule

// File: rtl/vert_flicker_filter.sv
module vert_flicker_filter
  import flick_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         pixValid,
  input  logic         lineStart,
  input  logic         frameStart,
  input  logic [1:0]   modeSel,
  input  logic         underscan,
  input  logic [W-1:0] lumaIn,
  input  logic [W-1:0] chromaIn,
  output logic         outValid,
  output logic [W-1:0] lumaOut,
  output logic [W-1:0] chromaOut
);

  localparam int AW = $clog2(DEPTH);

  ctl_s ctl;
  logic [AW-1:0] addr;
  logic [2*W-1:0] pixOut;

  flick_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .frameStart(frameStart), .ctl(ctl), .addr(addr)
  );

  flick_datapath #(.DEPTH(DEPTH), .W(W)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .modeIn(modeSel),
    .usIn(underscan), .pixIn({lumaIn, chromaIn}), .outValid(outValid),
    .pixOut(pixOut)
  );

  assign lumaOut   = pixOut[2*W-1:W];
  assign chromaOut = pixOut[W-1:0];

  // R10: nothing comes out in the cycle after reset
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !outValid);

endmodule

// File: tb/test_vert_flicker_filter.sv
module test_vert_flicker_filter;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0, lineStart = 1'b0, frameStart = 1'b0, underscan = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [7:0] lumaIn = '0, chromaIn = '0;
  logic outValid;
  logic [7:0] lumaOut, chromaOut;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  vert_flicker_filter i_vert_flicker_filter (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .frameStart(frameStart), .modeSel(modeSel), .underscan(underscan),
    .lumaIn(lumaIn), .chromaIn(chromaIn), .outValid(outValid),
    .lumaOut(lumaOut), .chromaOut(chromaOut)
  );

  // model state
  logic [7:0] m1Y [0:1023], m1C [0:1023], m2Y [0:1023], m2C [0:1023];
  int col = 0;
  bit seen = 0, prevFirst = 1, emitL = 0, aboveL = 0, belowL = 0;

  // two-deep expectation pipe
  bit pv0 = 0, pv1 = 0;
  logic [7:0] py0, py1, pc0, pc1;
  string pt0 = "R10", pt1 = "R10";

  function automatic logic [7:0] ref3(input int a, input int c, input int b,
                                      input int k);
    int q;
    case (k)
      0: q = c;                          // R1
      1: q = (a + 3 * c + b + 2) / 5;    // R2
      2: q = (a + 2 * c + b + 2) / 4;    // R3
      default: q = (a + c + b + 1) / 3;  // R4
    endcase
    if (q > 255) q = 255;
    return q[7:0];
  endfunction

  task automatic checkOut();
    nChecks++;
    if (outValid !== pv1) begin
      nFail++;
      $display("FAIL %s: outValid actual %0b expected %0b", pt1, outValid, pv1);
    end else if (pv1) begin
      nChecks++;
      if (lumaOut !== py1 || chromaOut !== pc1) begin
        nFail++;
        $display("FAIL %s: data actual %02h/%02h expected %02h/%02h",
                 pt1, lumaOut, chromaOut, py1, pc1);
      end
    end
  endtask

  task automatic cycle(input bit v, input bit ls, input bit fs,
                       input logic [7:0] y, input logic [7:0] c,
                       input logic [1:0] m, input bit us);
    int k, ay, ac, by, bc;
    @(negedge clk);
    checkOut();
    pv1 = pv0; py1 = py0; pc1 = pc0; pt1 = pt0;
    pv0 = 0; pt0 = "R9";
    pixValid = v; lineStart = ls; frameStart = fs;
    lumaIn = y; chromaIn = c; modeSel = m; underscan = us;
    if (v) begin
      if (ls) begin  // R11: column restart
        col = 0;
        emitL = seen;
        aboveL = !prevFirst;
        belowL = !fs;
        prevFirst = fs | !seen;
        seen = 1;
      end
      k = us ? 2 : int'(m);
      ay = aboveL ? int'(m2Y[col]) : int'(m1Y[col]);
      ac = aboveL ? int'(m2C[col]) : int'(m1C[col]);
      by = belowL ? int'(y) : int'(m1Y[col]);
      bc = belowL ? int'(c) : int'(m1C[col]);
      pv0 = emitL;
      py0 = ref3(ay, int'(m1Y[col]), by, k);
      pc0 = ref3(ac, int'(m1C[col]), bc, k);
      if (!emitL) pt0 = "R8";
      else if (us) pt0 = "R5";
      else if (!belowL) pt0 = "R7";
      else if (!aboveL) pt0 = "R6";
      else case (k)
        0: pt0 = "R1";
        1: pt0 = "R2";
        2: pt0 = "R3";
        default: pt0 = "R4";
      endcase
      m2Y[col] = m1Y[col]; m2C[col] = m1C[col];
      m1Y[col] = y; m1C[col] = c;
      col++;
    end
  endtask

  // one line of samples, ramp data, optional idle gaps carrying junk markers
  task automatic sendLine(input bit fs, input int len, input logic [1:0] m,
                          input bit us, input logic [7:0] y0, input logic [7:0] ys,
                          input logic [7:0] c0, input logic [7:0] cs,
                          input int gapPct);
    for (int i = 0; i < len; i++) begin
      while (int'($urandom % 100) < gapPct)
        cycle(0, 1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom), m, us);
      cycle(1, i == 0, fs && i == 0, 8'(y0 + ys * i), 8'(c0 + cs * i), m, us);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 1024; i++) begin
      m1Y[i] = '0; m1C[i] = '0; m2Y[i] = '0; m2C[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R10: reset state
    nChecks++;
    if (outValid !== 1'b0) begin
      nFail++;
      $display("FAIL R10: outValid actual %0b expected 0", outValid);
    end
    rstN = 1'b1;

    // directed: frame of ramps, 1:2:1, first line yields nothing (R8), R6
    sendLine(1, 12, 2'b10, 0, 8'd10, 8'd20, 8'd200, 8'd7, 0);
    sendLine(0, 12, 2'b10, 0, 8'd50, 8'd3, 8'd9, 8'd11, 0);
    sendLine(0, 12, 2'b10, 0, 8'd250, 8'd1, 8'd0, 8'd0, 0);
    // stripes 0/255/0 under 1:3:1 (R2) and rounding; frame change gives R7
    sendLine(1, 12, 2'b01, 0, 8'd0, 8'd0, 8'd255, 8'd0, 0);
    sendLine(0, 12, 2'b01, 0, 8'd255, 8'd0, 8'd0, 8'd0, 0);
    sendLine(0, 12, 2'b01, 0, 8'd0, 8'd1, 8'd255, 8'd0, 0);
    // 1:1:1 (R4), then pass-through (R1)
    sendLine(0, 12, 2'b11, 0, 8'd1, 8'd2, 8'd128, 8'd5, 0);
    sendLine(0, 12, 2'b00, 0, 8'd77, 8'd9, 8'd33, 8'd13, 0);
    // underscan overrides pass-through select (R5)
    sendLine(0, 12, 2'b00, 1, 8'd255, 8'd0, 8'd4, 8'd21, 0);
    // single-line frame: both neighbours substituted (R6, R7)
    sendLine(1, 12, 2'b11, 0, 8'd90, 8'd15, 8'd60, 8'd4, 0);
    sendLine(1, 12, 2'b01, 0, 8'd3, 8'd30, 8'd99, 8'd1, 30);

    // random frames: gaps with junk markers (R9), varied lengths (R11)
    for (int f = 0; f < 40; f++) begin
      int nLines, len;
      nLines = 1 + int'($urandom % 6);
      len = 8 + int'($urandom % 5);
      for (int l = 0; l < nLines; l++)
        sendLine(l == 0, len, 2'($urandom), ($urandom % 4) == 0,
                 8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom), 25);
    end

    // drain the pipe
    repeat (3) cycle(0, 0, 0, 8'd0, 8'd0, 2'b00, 0);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule